// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block sits behind a byte-oriented serial receiver in a slow-rate infrared link. It watches the stream of received bytes and keeps only the frame contents. Bytes that arrive outside a frame are dropped. Runs of begin flags before the frame body are stripped. Escape sequences are undone. The address, control, information and trailing check-sequence bytes are then handed to a receive FIFO, one per strobe. The first forwarded byte of each frame carries a start marker.

At frame close, a one-cycle end marker is raised together with the frame's byte count and an error code. The byte count is 12 bits wide and is compared against a programmable upper limit. A frame that runs past the limit is cut short and flagged. A begin flag that arrives inside a frame also ends that frame with its own error code, and opens the next frame. Check-sequence verification and bit-level deserialisation belong to other blocks.

Top module: `sir_rx_unwrap`

## Requirements
- R1: `flag_reg_o` reads 0xC1C0: the end flag 0xC1 sits in bits [15:8] and the begin flag 0xC0 in bits [7:0].
- R2: Filtering is active when `sir_mode_i` and `filt_en_i` are both 1, or when `filt_test_i` is 1. While filtering is inactive, input bytes cause no output and no frame end, and the unwrapper goes back to the outside-frame state.
- R3: Outside a frame, every byte other than 0xC0 is discarded. This includes 0xC1.
- R4: After a frame opens, further 0xC0 bytes are stripped until the first body byte arrives. The first forwarded byte of a frame is flagged with `out_sof_o`.
- R5: Each body byte, including the check-sequence bytes, appears on `out_data_o` with `out_valid_o` one clock after its input strobe, in arrival order.
- R6: The escape byte 0x7D is not forwarded. The byte that follows it is forwarded XORed with 0x20.
- R7: Inside a frame, 0xC1 pulses `frame_end_o` for one cycle. At the same time `frame_len_o` holds the number of bytes forwarded and `frame_err_o` is 0x00. An empty frame reports length 0.
- R8: Inside a frame body, 0xC0 closes the frame with `frame_err_o` = 0x04 (bit 2). It then opens a new frame, whose count starts again at 0.
- R9: `byte_cnt_o` clears to 0 when a frame opens and increases by exactly 1 for each forwarded byte.
- R10: A body byte that arrives when the count already equals `max_len_i` is not forwarded. The frame closes with `frame_err_o` = 0x10 (bit 4) and `frame_len_o` = `max_len_i`. Later bytes are discarded, with no further frame end, until the next flag.
- R11: After reset, `out_valid_o`, `out_sof_o`, `frame_end_o`, `frame_err_o`, `frame_len_o` and `byte_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sir_mode_i | input | 1 | Slow-rate mode selected |
| filt_en_i | input | 1 | Unwrap filter enable |
| filt_test_i | input | 1 | Run the filter in any mode |
| max_len_i | input | 12 | Largest accepted frame length in bytes |
| rx_byte_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| out_data_o | output | 8 | Unwrapped byte to FIFO |
| out_valid_o | output | 1 | FIFO write strobe |
| out_sof_o | output | 1 | First byte of a frame |
| frame_end_o | output | 1 | Frame close pulse |
| frame_len_o | output | 12 | Byte count of the closed frame |
| frame_err_o | output | 8 | Error code of the closed frame |
| byte_cnt_o | output | 12 | Live per-frame byte count |
| flag_reg_o | output | 16 | Constant end/begin flag values |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 12-bit count and escape handling switched on. Because `max_len_i` is a port, the bench can set it to 3. That makes the oversize cut, the discard-until-flag behaviour after it, and recovery into the next frame reachable with a handful of bytes, without sending thousands. Escaped flags, stacked begin flags, empty frames and a begin flag in the middle of a frame are all driven directly.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BODY,
    ST_ESC,
    ST_DROP
  } rx_state_e;

  typedef struct packed {
    logic is_bof;
    logic is_eof;
    logic is_esc;
  } byte_class_t;

  localparam int unsigned ERR_BOF_IDX = 2;
  localparam int unsigned ERR_LEN_IDX = 4;
endpackage

// File: rtl/sir_byte_classify.sv
module sir_byte_classify
  import sir_unwrap_pkg::*;
#(
  parameter int unsigned      DATA_W = 8,
  parameter logic [DATA_W-1:0] BOF   = 8'hC0,
  parameter logic [DATA_W-1:0] EOF   = 8'hC1,
  parameter logic [DATA_W-1:0] ESC   = 8'h7D,
  parameter bit               ESC_EN = 1'b1
) (
  input  logic [DATA_W-1:0] byte_i,
  output byte_class_t       cls_o
);
  assign cls_o.is_bof = (byte_i == BOF);
  assign cls_o.is_eof = (byte_i == EOF);

  generate
    if (ESC_EN) begin : g_esc
      assign cls_o.is_esc = (byte_i == ESC);
    end else begin : g_no_esc
      assign cls_o.is_esc = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sir_len_counter.sv
module sir_len_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q >= limit_i);

  assert_inc_below_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !full_o);
  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == $past(cnt_o) + 1'b1);
  assert_clear_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/sir_unwrap_fsm.sv
module sir_unwrap_fsm
  import sir_unwrap_pkg::*;
#(
  parameter int unsigned       DATA_W  = 8,
  parameter int unsigned       CNT_W   = 12,
  parameter int unsigned       ERR_W   = 8,
  parameter logic [DATA_W-1:0] ESC_XOR = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  byte_class_t       cls_i,
  input  logic              full_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic              inc_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_sof_o,
  output logic              frame_end_o,
  output logic [CNT_W-1:0]  frame_len_o,
  output logic [ERR_W-1:0]  frame_err_o
);
  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] wr_data;
  logic              close;
  logic [ERR_W-1:0]  close_err;

  always_comb begin
    state_d   = state_q;
    clr_o     = 1'b0;
    inc_o     = 1'b0;
    wr_data   = byte_i;
    close     = 1'b0;
    close_err = '0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else if (valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cls_i.is_bof) begin
            state_d = ST_OPEN;
            clr_o   = 1'b1;
          end
        end
        ST_DROP: begin
          if (cls_i.is_bof) begin
            state_d = ST_OPEN;
            clr_o   = 1'b1;
          end else if (cls_i.is_eof) begin
            state_d = ST_IDLE;
          end
        end
        ST_OPEN, ST_BODY, ST_ESC: begin
          if (cls_i.is_bof) begin
            clr_o   = 1'b1;
            state_d = ST_OPEN;
            if (state_q != ST_OPEN) begin
              close                  = 1'b1;
              close_err[ERR_BOF_IDX] = 1'b1;
            end
          end else if (cls_i.is_eof) begin
            close   = 1'b1;
            state_d = ST_IDLE;
          end else if (cls_i.is_esc && state_q != ST_ESC) begin
            state_d = ST_ESC;
          end else begin
            wr_data = (state_q == ST_ESC) ? (byte_i ^ ESC_XOR) : byte_i;
            if (full_i) begin
              close                  = 1'b1;
              close_err[ERR_LEN_IDX] = 1'b1;
              state_d                = ST_DROP;
            end else begin
              inc_o   = 1'b1;
              state_d = ST_BODY;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      frame_end_o <= 1'b0;
      frame_len_o <= '0;
      frame_err_o <= '0;
    end else begin
      state_q     <= state_d;
      out_valid_o <= inc_o;
      out_sof_o   <= inc_o && (cnt_i == '0);
      frame_end_o <= close;
      if (inc_o) out_data_o <= wr_data;
      if (close) begin
        frame_len_o <= cnt_i;
        frame_err_o <= close_err;
      end
    end
  end

  assert_disabled_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!out_valid_o && !frame_end_o));
  assert_close_no_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && frame_end_o));
  assert_sof_with_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o);
  assert_single_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> $countones(frame_err_o) <= 1);
  assert_idle_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !inc_o);
endmodule

// File: rtl/sir_rx_unwrap.sv
module sir_rx_unwrap
  import sir_unwrap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned ERR_W  = 8,
  parameter logic [DATA_W-1:0] BOF     = 8'hC0,
  parameter logic [DATA_W-1:0] EOF     = 8'hC1,
  parameter logic [DATA_W-1:0] ESC     = 8'h7D,
  parameter logic [DATA_W-1:0] ESC_XOR = 8'h20,
  parameter bit                ESC_EN  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sir_mode_i,
  input  logic                filt_en_i,
  input  logic                filt_test_i,
  input  logic [CNT_W-1:0]    max_len_i,
  input  logic [DATA_W-1:0]   rx_byte_i,
  input  logic                rx_valid_i,
  output logic [DATA_W-1:0]   out_data_o,
  output logic                out_valid_o,
  output logic                out_sof_o,
  output logic                frame_end_o,
  output logic [CNT_W-1:0]    frame_len_o,
  output logic [ERR_W-1:0]    frame_err_o,
  output logic [CNT_W-1:0]    byte_cnt_o,
  output logic [2*DATA_W-1:0] flag_reg_o
);
  byte_class_t      cls;
  logic             en, clr, inc, full;
  logic [CNT_W-1:0] cnt;

  assign en         = (sir_mode_i && filt_en_i) || filt_test_i;
  assign flag_reg_o = {EOF, BOF};
  assign byte_cnt_o = cnt;

  sir_byte_classify #(
    .DATA_W(DATA_W), .BOF(BOF), .EOF(EOF), .ESC(ESC), .ESC_EN(ESC_EN)
  ) u_classify (
    .byte_i(rx_byte_i),
    .cls_o (cls)
  );

  sir_len_counter #(.CNT_W(CNT_W)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .limit_i(max_len_i),
    .cnt_o  (cnt),
    .full_o (full)
  );

  sir_unwrap_fsm #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .ESC_XOR(ESC_XOR)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .byte_i     (rx_byte_i),
    .valid_i    (rx_valid_i),
    .cls_i      (cls),
    .full_i     (full),
    .cnt_i      (cnt),
    .clr_o      (clr),
    .inc_o      (inc),
    .out_data_o (out_data_o),
    .out_valid_o(out_valid_o),
    .out_sof_o  (out_sof_o),
    .frame_end_o(frame_end_o),
    .frame_len_o(frame_len_o),
    .frame_err_o(frame_err_o)
  );

  assert_len_within_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && frame_err_o[ERR_LEN_IDX]) |-> frame_len_o == $past(max_len_i));
endmodule

// File: tb/sir_rx_unwrap_tb_top.sv
module sir_rx_unwrap_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sir_mode, filt_en, filt_test;
  logic [11:0] max_len;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic [7:0]  out_data;
  logic        out_valid, out_sof, frame_end;
  logic [11:0] frame_len, byte_cnt;
  logic [7:0]  frame_err;
  logic [15:0] flag_reg;

  int n_chk = 0;
  int n_fail = 0;

  logic        l_v, l_sof, l_end;
  logic [7:0]  l_d, l_err;
  logic [11:0] l_len, l_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_rx_unwrap dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sir_mode_i(sir_mode), .filt_en_i(filt_en),
    .filt_test_i(filt_test), .max_len_i(max_len), .rx_byte_i(rx_byte),
    .rx_valid_i(rx_valid), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_sof_o(out_sof), .frame_end_o(frame_end), .frame_len_o(frame_len),
    .frame_err_o(frame_err), .byte_cnt_o(byte_cnt), .flag_reg_o(flag_reg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(posedge clk);
    #1;
    l_v = out_valid; l_d = out_data; l_sof = out_sof; l_end = frame_end;
    l_len = frame_len; l_err = frame_err; l_cnt = byte_cnt;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_data(input logic [7:0] d, input bit sof, input string req);
    chk(l_v == 1'b1, req, l_v, 1);
    chk(l_d == d, req, l_d, d);
    chk(l_sof == sof, req, l_sof, sof);
    chk(l_end == 1'b0, req, l_end, 0);
  endtask

  task automatic expect_quiet(input string req);
    chk(l_v == 1'b0, req, l_v, 0);
    chk(l_end == 1'b0, req, l_end, 0);
  endtask

  task automatic expect_close(input int len, input int err, input string req);
    chk(l_end == 1'b1, req, l_end, 1);
    chk(l_v == 1'b0, req, l_v, 0);
    chk(l_len == 12'(len), req, l_len, len);
    chk(l_err == 8'(err), req, l_err, err);
  endtask

  task automatic t_reset;
    chk(out_valid == 0 && out_sof == 0 && frame_end == 0, "R11 flags", {out_valid, out_sof, frame_end}, 0);
    chk(frame_len == 0 && frame_err == 0, "R11 frame info", {frame_len, frame_err}, 0);
    chk(byte_cnt == 0, "R11 count", byte_cnt, 0);
    chk(flag_reg == 16'hC1C0, "R1 flags", flag_reg, 16'hC1C0);
  endtask

  task automatic t_outside;
    send(8'h11); expect_quiet("R3 stray byte");
    send(8'hC1); expect_quiet("R3 stray end flag");
    send(8'h7D); expect_quiet("R3 stray escape");
  endtask

  task automatic t_basic;
    send(8'hC0); expect_quiet("R4 open");
    send(8'hC0); expect_quiet("R4 extra bof");
    send(8'hC0); expect_quiet("R4 extra bof");
    chk(l_cnt == 0, "R9 count after open", l_cnt, 0);
    send(8'hA1); expect_data(8'hA1, 1, "R4 R5 first byte");
    chk(l_cnt == 1, "R9 count", l_cnt, 1);
    send(8'h02); expect_data(8'h02, 0, "R5 byte2");
    send(8'h33); expect_data(8'h33, 0, "R5 fcs lo");
    send(8'h44); expect_data(8'h44, 0, "R5 fcs hi");
    chk(l_cnt == 4, "R9 count", l_cnt, 4);
    send(8'hC1); expect_close(4, 0, "R7 close");
    send(8'h55); expect_quiet("R3 after close");
    send(8'hC0); send(8'hC1); expect_close(0, 0, "R7 empty frame");
  endtask

  task automatic t_escape;
    send(8'hC0);
    send(8'h7D); expect_quiet("R6 escape dropped");
    send(8'h5E); expect_data(8'h7E, 1, "R6 unescape");
    send(8'h7D); expect_quiet("R6 escape dropped");
    send(8'h5D); expect_data(8'h7D, 0, "R6 escaped escape");
    send(8'h7D); send(8'hE0); expect_data(8'hC0, 0, "R6 escaped bof value");
    send(8'hC1); expect_close(3, 0, "R7 R6 close len");
  endtask

  task automatic t_bof_mid;
    send(8'hC0); send(8'h10); send(8'h20);
    send(8'hC0); expect_close(2, 8'h04, "R8 bof inside");
    chk(l_cnt == 0, "R8 R9 count restarts", l_cnt, 0);
    send(8'h30); expect_data(8'h30, 1, "R8 new frame first byte");
    send(8'hC1); expect_close(1, 0, "R8 new frame close");
  endtask

  task automatic t_oversize;
    max_len = 12'd3;
    send(8'hC0);
    send(8'h01); expect_data(8'h01, 1, "R10 b1");
    send(8'h02); expect_data(8'h02, 0, "R10 b2");
    send(8'h03); expect_data(8'h03, 0, "R10 b3");
    send(8'h04); expect_close(3, 8'h10, "R10 overflow close");
    send(8'h05); expect_quiet("R10 drop after overflow");
    send(8'hC1); expect_quiet("R10 eof after overflow");
    send(8'hC0); send(8'h09); expect_data(8'h09, 1, "R10 recovery");
    send(8'hC1); expect_close(1, 0, "R10 recovery close");
    max_len = 12'hFFF;
  endtask

  task automatic t_disable;
    sir_mode = 1'b0; filt_en = 1'b1; filt_test = 1'b0;
    send(8'hC0); expect_quiet("R2 disabled bof");
    send(8'h55); expect_quiet("R2 disabled data");
    send(8'hC1); expect_quiet("R2 disabled eof");
    filt_test = 1'b1;
    send(8'hC0); send(8'h66); expect_data(8'h66, 1, "R2 test mode");
    filt_test = 1'b0;
    send(8'h67); expect_quiet("R2 disabled mid frame");
    sir_mode = 1'b1;
    send(8'h77); expect_quiet("R2 state returned to idle");
    send(8'hC0); send(8'h77); expect_data(8'h77, 1, "R2 reenabled");
    send(8'hC1); expect_close(1, 0, "R2 reenabled close");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    sir_mode = 1'b1; filt_en = 1'b1; filt_test = 1'b0;
    max_len = 12'hFFF; rx_byte = 8'h00; rx_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    t_outside;
    t_basic;
    t_escape;
    t_bof_mid;
    t_oversize;
    t_disable;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule